// File: doc/BRIEF.md
# Multithreaded VPE Run-Control Unit

This block decides, for each virtual processing element (VPE) of a multithreaded core, whether that VPE runs or sleeps. It holds one global enable bit. For every VPE it also holds an activation bit, a thread-active bit, a thread-halt bit, a halted flag and a sticky wake request. Each VPE's state sits in its own slice. A small arbiter picks one command per cycle from the strobes that arrive.

Software-level operations reach the block as one-cycle strobes:
- disable-all, enable-all and wait are tagged with the issuing VPE;
- a thread-halt write and a configuration write are tagged with their target VPE.

Per-VPE interrupt lines feed a has-work term. A halted VPE resumes once it has work. Disable-all and enable-all return the control value that held before they acted.

Top module: `vpe_run_ctl`

## Requirements
- R1: A VPE is active only when the global enable, its activation bit and its thread-active bit are all 1 and its thread-halt bit is 0. `has_work[i]` is (irq[i] OR wake pending) AND active.
- R2: After reset, VPE 0 is activated, its thread is active and it is running. Every other VPE is deactivated and halted. The global enable is 1 and no wake is pending. So `run` = 1 (bit 0 only set), `has_work` = 0 and `prev_vld` = 0.
- R3: A wait from VPE v halts v on the next edge and clears v's pending wake.
- R4: A halted VPE whose `has_work` is 1 clears its halted flag on the next edge. `run[i]` is the inverse of the halted flag.
- R5: Disable-all clears the global enable. It halts every VPE except the issuer and clears their wake requests. The issuer keeps running.
- R6: Disable-all and enable-all set `prev_vld` for one cycle. In that cycle `prev_ctrl` bit 0 holds the global enable from before the command, and the upper bits are 0.
- R7: A thread-halt write keeps only bit 0 of `th_data`. Writing 1 halts the target and clears its wake. Writing 0 raises a wake only when the target becomes active and is not halted.
- R8: A wake request is sticky. It stays pending while the VPE is inactive. When a later write makes the VPE active, the VPE resumes.
- R9: Only one command is taken per cycle. The priority is disable-all, then enable-all, then wait, then thread-halt write, then configuration write.
- R10: A configuration write loads the target's activation and thread-active bits. It does not by itself clear the halted flag.
- R11: Enable-all sets the global enable and raises a wake on every VPE except the issuer. It skips any VPE that is in wait-for-interrupt (halted while active).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis_all | input | 1 | Disable-all strobe |
| en_all | input | 1 | Enable-all strobe |
| wait_cmd | input | 1 | Wait strobe |
| cmd_vpe | input | IDW | Issuer of disable-all, enable-all and wait |
| th_wr | input | 1 | Thread-halt write strobe |
| th_vpe | input | IDW | Thread-halt write target |
| th_data | input | DW | Thread-halt write data (bit 0 used) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_vpe | input | IDW | Configuration write target |
| cfg_vpa | input | 1 | New activation bit |
| cfg_tca | input | 1 | New thread-active bit |
| irq | input | N | Per-VPE interrupt pending |
| run | output | N | Per-VPE running (not halted) |
| has_work | output | N | Per-VPE has-work |
| prev_vld | output | 1 | `prev_ctrl` valid |
| prev_ctrl | output | DW | Control value before the last disable-all or enable-all |

## Verification
The assertions assume that every tag (`cmd_vpe`, `th_vpe`, `cfg_vpe`) names an existing VPE. The resume property further assumes that no command strobe is present in the same cycle, since any command overrides the resume. The stimulus gives each strobe for one cycle only and keeps every tag below N. The one deliberate exception is the priority scenario, which sets several strobes together. The interrupt lines are changed only at the falling edge, so `has_work` is sampled stable.

// File: rtl/vpe_rc_pkg.sv
package vpe_rc_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_DIS  = 3'd1,
    CMD_EN   = 3'd2,
    CMD_WAIT = 3'd3,
    CMD_THW  = 3'd4,
    CMD_CFG  = 3'd5
  } cmd_e;
endpackage

// File: rtl/vpe_cmd_arb.sv
module vpe_cmd_arb
  import vpe_rc_pkg::*;
(
  input  logic dis_all,
  input  logic en_all,
  input  logic wait_cmd,
  input  logic th_wr,
  input  logic cfg_wr,
  output cmd_e cmd
);
  // fixed priority, one winner per cycle
  always_comb begin
    if (dis_all)       cmd = CMD_DIS;
    else if (en_all)   cmd = CMD_EN;
    else if (wait_cmd) cmd = CMD_WAIT;
    else if (th_wr)    cmd = CMD_THW;
    else if (cfg_wr)   cmd = CMD_CFG;
    else               cmd = CMD_NONE;
  end
endmodule

// File: rtl/vpe_slice.sv
module vpe_slice
  import vpe_rc_pkg::*;
#(
  parameter bit RESET_ON = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic glob_en,
  input  cmd_e cmd,
  input  logic is_issuer,
  input  logic is_th_tgt,
  input  logic is_cfg_tgt,
  input  logic th_bit,
  input  logic cfg_vpa,
  input  logic cfg_tca,
  input  logic irq,
  output logic halted_o,
  output logic has_work_o
);
  logic vpa_q, tca_q, thalt_q, halted_q, wake_q;
  logic active, wfi, work, active_if_run;

  assign active        = glob_en & vpa_q & tca_q & ~thalt_q;
  assign active_if_run = glob_en & vpa_q & tca_q;
  assign wfi           = halted_q & active;
  assign work          = (irq | wake_q) & active;

  always_ff @(posedge clk) begin
    if (rst) begin
      vpa_q    <= RESET_ON;
      tca_q    <= RESET_ON;
      thalt_q  <= 1'b0;
      halted_q <= ~RESET_ON;
      wake_q   <= 1'b0;
    end else begin
      if (halted_q && work) halted_q <= 1'b0;
      unique case (cmd)
        CMD_DIS: if (!is_issuer) begin
          halted_q <= 1'b1;
          wake_q   <= 1'b0;
        end
        CMD_EN: if (!is_issuer && !wfi) wake_q <= 1'b1;
        CMD_WAIT: if (is_issuer) begin
          halted_q <= 1'b1;
          wake_q   <= 1'b0;
        end
        CMD_THW: if (is_th_tgt) begin
          thalt_q <= th_bit;
          if (th_bit) begin
            halted_q <= 1'b1;
            wake_q   <= 1'b0;
          end else if (active_if_run && !halted_q) begin
            wake_q <= 1'b1;
          end
        end
        CMD_CFG: if (is_cfg_tgt) begin
          vpa_q <= cfg_vpa;
          tca_q <= cfg_tca;
        end
        default: ;
      endcase
    end
  end

  assign halted_o   = halted_q;
  assign has_work_o = work;
endmodule

// File: rtl/vpe_run_ctl.sv
module vpe_run_ctl
  import vpe_rc_pkg::*;
#(
  parameter int N   = 4,
  parameter int DW  = 32,
  parameter int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dis_all,
  input  logic           en_all,
  input  logic           wait_cmd,
  input  logic [IDW-1:0] cmd_vpe,
  input  logic           th_wr,
  input  logic [IDW-1:0] th_vpe,
  input  logic [DW-1:0]  th_data,
  input  logic           cfg_wr,
  input  logic [IDW-1:0] cfg_vpe,
  input  logic           cfg_vpa,
  input  logic           cfg_tca,
  input  logic [N-1:0]   irq,
  output logic [N-1:0]   run,
  output logic [N-1:0]   has_work,
  output logic           prev_vld,
  output logic [DW-1:0]  prev_ctrl
);
  cmd_e       cmd;
  logic       glob_en_q;
  logic [N-1:0] halted;

  vpe_cmd_arb u_arb (
    .dis_all (dis_all),
    .en_all  (en_all),
    .wait_cmd(wait_cmd),
    .th_wr   (th_wr),
    .cfg_wr  (cfg_wr),
    .cmd     (cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en_q <= 1'b1;
      prev_vld  <= 1'b0;
      prev_ctrl <= '0;
    end else begin
      prev_vld <= (cmd == CMD_DIS) || (cmd == CMD_EN);
      if (cmd == CMD_DIS || cmd == CMD_EN)
        prev_ctrl <= {{(DW-1){1'b0}}, glob_en_q};
      if (cmd == CMD_DIS) glob_en_q <= 1'b0;
      else if (cmd == CMD_EN) glob_en_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_vpe
    vpe_slice #(.RESET_ON(i == 0)) u_slice (
      .clk       (clk),
      .rst       (rst),
      .glob_en   (glob_en_q),
      .cmd       (cmd),
      .is_issuer (cmd_vpe == IDW'(i)),
      .is_th_tgt (th_vpe == IDW'(i)),
      .is_cfg_tgt(cfg_vpe == IDW'(i)),
      .th_bit    (th_data[0]),
      .cfg_vpa   (cfg_vpa),
      .cfg_tca   (cfg_tca),
      .irq       (irq[i]),
      .halted_o  (halted[i]),
      .has_work_o(has_work[i])
    );
  end

  assign run = ~halted;
endmodule

// File: rtl/vpe_run_ctl_chk.sv
module vpe_run_ctl_chk #(
  parameter int N   = 4,
  parameter int DW  = 32,
  parameter int IDW = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           dis_all,
  input logic           en_all,
  input logic           wait_cmd,
  input logic [IDW-1:0] cmd_vpe,
  input logic           th_wr,
  input logic [IDW-1:0] th_vpe,
  input logic [DW-1:0]  th_data,
  input logic           cfg_wr,
  input logic [N-1:0]   run,
  input logic [N-1:0]   has_work,
  input logic           prev_vld
);
  logic any_cmd;
  assign any_cmd = dis_all | en_all | wait_cmd | th_wr | cfg_wr;

  assert_reset_state_R2: assert property (@(posedge clk)
    rst |=> (run == N'(1) && !prev_vld));

  assert_prev_valid_R6: assert property (@(posedge clk) disable iff (rst)
    (dis_all || en_all) |=> prev_vld);

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_wait_halts_R3: assert property (@(posedge clk) disable iff (rst)
      (wait_cmd && !dis_all && !en_all && cmd_vpe == IDW'(i)) |=> !run[i]);

    assert_resume_R4: assert property (@(posedge clk) disable iff (rst)
      (!run[i] && has_work[i] && !any_cmd) |=> run[i]);

    assert_disable_halts_R5: assert property (@(posedge clk) disable iff (rst)
      (dis_all && cmd_vpe != IDW'(i)) |=> (!run[i] && !has_work[i]));

    assert_thalt_sleep_R7: assert property (@(posedge clk) disable iff (rst)
      (th_wr && th_data[0] && th_vpe == IDW'(i) && !dis_all && !en_all && !wait_cmd)
      |=> !run[i]);
  end
endmodule

bind vpe_run_ctl vpe_run_ctl_chk #(.N(N), .DW(DW), .IDW(IDW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .dis_all (dis_all),
  .en_all  (en_all),
  .wait_cmd(wait_cmd),
  .cmd_vpe (cmd_vpe),
  .th_wr   (th_wr),
  .th_vpe  (th_vpe),
  .th_data (th_data),
  .cfg_wr  (cfg_wr),
  .run     (run),
  .has_work(has_work),
  .prev_vld(prev_vld)
);

// File: tb/tb_vpe_run_ctl.sv
module tb_vpe_run_ctl;
  localparam int N = 4, DW = 32, IDW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic dis_all = 0, en_all = 0, wait_cmd = 0, th_wr = 0, cfg_wr = 0;
  logic cfg_vpa = 0, cfg_tca = 0;
  logic [IDW-1:0] cmd_vpe = '0, th_vpe = '0, cfg_vpe = '0;
  logic [DW-1:0] th_data = '0;
  logic [N-1:0] irq = '0, run, has_work;
  logic prev_vld;
  logic [DW-1:0] prev_ctrl;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vpe_run_ctl #(.N(N), .DW(DW)) dut (
    .clk(clk), .rst(rst), .dis_all(dis_all), .en_all(en_all), .wait_cmd(wait_cmd),
    .cmd_vpe(cmd_vpe), .th_wr(th_wr), .th_vpe(th_vpe), .th_data(th_data),
    .cfg_wr(cfg_wr), .cfg_vpe(cfg_vpe), .cfg_vpa(cfg_vpa), .cfg_tca(cfg_tca),
    .irq(irq), .run(run), .has_work(has_work), .prev_vld(prev_vld), .prev_ctrl(prev_ctrl)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic cmd(input logic d, input logic e, input logic w, input int v);
    dis_all = d; en_all = e; wait_cmd = w; cmd_vpe = IDW'(v);
    @(negedge clk);
    dis_all = 0; en_all = 0; wait_cmd = 0;
    #1;
  endtask

  task automatic thw(input int v, input logic [DW-1:0] d);
    th_wr = 1; th_vpe = IDW'(v); th_data = d;
    @(negedge clk);
    th_wr = 0;
    #1;
  endtask

  task automatic cfg(input int v, input logic a, input logic t);
    cfg_wr = 1; cfg_vpe = IDW'(v); cfg_vpa = a; cfg_tca = t;
    @(negedge clk);
    cfg_wr = 0;
    #1;
  endtask

  task automatic t_reset;
    chk("R2 run", run, 32'h1);
    chk("R2 has_work", has_work, 0);
    chk("R2 prev_vld", prev_vld, 0);
  endtask

  task automatic t_cfg_irq;
    irq[2] = 1; #1;
    chk("R1 inactive no work", has_work[2], 0);
    irq[2] = 0;
    cfg(1, 1, 1);
    chk("R10 cfg no resume", run[1], 0);
    chk("R10 cfg no work", has_work[1], 0);
    irq[1] = 1; #1;
    chk("R1 irq work", has_work[1], 1);
    tick(1);
    chk("R4 resume", run[1], 1);
    irq[1] = 0;
  endtask

  task automatic t_wait;
    cmd(0, 1, 0, 0);
    chk("R6 prev enable", prev_ctrl, 1);
    chk("R11 wake running", has_work[1], 1);
    chk("R1 wake inactive", has_work[2], 0);
    cmd(0, 0, 1, 1);
    chk("R3 wait halts", run[1], 0);
    chk("R3 wake cleared", has_work[1], 0);
    tick(2);
    chk("R3 stays halted", run[1], 0);
  endtask

  task automatic t_skip_wfi;
    cmd(0, 1, 0, 0);
    chk("R11 wfi not woken", has_work[1], 0);
    tick(2);
    chk("R11 wfi stays", run[1], 0);
    irq[1] = 1;
    tick(1);
    chk("R4 irq resume", run[1], 1);
    irq[1] = 0;
  endtask

  task automatic t_sticky;
    cfg(2, 1, 1);
    chk("R8 sticky work", has_work[2], 1);
    tick(1);
    chk("R8 sticky resume", run, 32'h7);
  endtask

  task automatic t_thalt;
    thw(2, 32'hFFFF_FFFE);
    chk("R7 bit0 only", run[2], 1);
    thw(2, 32'h1);
    chk("R7 halt sleeps", run[2], 0);
    chk("R7 halt clears wake", has_work[2], 0);
    thw(2, 32'h0);
    chk("R7 wfi no wake", has_work[2], 0);
    tick(1);
    chk("R7 wfi stays", run[2], 0);
    irq[2] = 1;
    tick(1);
    irq[2] = 0; #1;
    chk("R4 resume 2", run[2], 1);
    thw(2, 32'h2);
    chk("R7 zero write wakes", has_work[2], 1);
  endtask

  task automatic t_disable;
    cmd(1, 0, 0, 1);
    chk("R6 prev vld", prev_vld, 1);
    chk("R6 prev disable", prev_ctrl, 1);
    chk("R5 others halted", run, 32'h2);
    chk("R5 no work", has_work, 0);
    irq[1] = 1; #1;
    chk("R1 global off", has_work[1], 0);
    irq[1] = 0;
  endtask

  task automatic t_prio;
    cmd(1, 1, 1, 1);
    chk("R9 disable wins prev", prev_ctrl, 0);
    chk("R9 wait dropped", run, 32'h2);
    cmd(0, 1, 0, 1);
    chk("R6 prev zero", prev_ctrl, 0);
    chk("R11 wake others", has_work, 32'h5);
    tick(1);
    chk("R11 resumed", run, 32'h7);
    th_wr = 1; th_vpe = 2; th_data = 1;
    cmd(0, 0, 1, 0);
    th_wr = 0;
    chk("R9 wait over thw", run, 32'h6);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    #1;
    t_reset();
    t_cfg_irq();
    t_wait();
    t_skip_wfi();
    t_sticky();
    t_thalt();
    t_disable();
    t_prio();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule